// File: doc/BRIEF.md
# Link Receive Handshake Responder

This block is the receiving half of a serial storage link layer. It watches an incoming stream of 32-bit dwords, each already marked as a control primitive or as payload, with repeat compression already removed. From each dword and its own frame state it picks the primitive the transmitter should send back: ready, receive-in-progress, hold acknowledge, good or bad end, or the idle code.

Between a start-of-frame primitive and the terminate-wait primitive it gathers the payload dwords and descrambles each one. Descrambling uses a sequence that restarts at every frame. The last payload dword is the checksum, so the block holds each descrambled dword for one step. Every dword except the final one is passed to the transport side and folded into a running CRC-32. When the terminate-wait primitive arrives, the held dword is compared with that CRC. The block then pulses a frame-end strobe, reports the result and picks a good or bad reply.

Top module: `link_rx_responder`

## Requirements
- R1: After reset `reply_code` is 0 (idle), and `pay_valid` and `frame_end` are low.
- R2: A primitive with `in_data[3:0]` = 1 (transmit-ready), received outside a frame, makes `reply_code` 1 (receiver-ready) on the next cycle.
- R3: A primitive with `in_data[3:0]` = 3 (hold) makes `reply_code` 3 (hold acknowledge) on the next cycle, inside or outside a frame.
- R4: A primitive with `in_data[3:0]` = 2 (start of frame) opens a frame and makes `reply_code` 2 (in progress). While a frame is open, any data dword or other primitive except hold, end and terminate-wait also gives `reply_code` 2.
- R5: A primitive with `in_data[3:0]` = 4 (end of frame) leaves `reply_code` unchanged, and so does a cycle with `in_valid` low. Outside a frame, a data dword or a primitive of any other code gives `reply_code` 0.
- R6: Data dword k of a frame (k counted from 0 after start of frame) is XORed with scrambler word k. The scrambler is a 16-bit register seeded 0xF0F6 at each start of frame. Each output bit is register bit 15, after which the register shifts left and takes in bit15^bit14^bit12^bit3. Each word collects 32 output bits, the first bit in bit 31.
- R7: Every descrambled dword except the last of a frame appears on `pay_data` with a one-cycle `pay_valid`, in order. A dword appears in the cycle after the following data dword is received.
- R8: The checksum is CRC-32, polynomial 0x04C11DB7, seed 0x52325032, taken MSB first over the delivered dwords, with no reflection and no final XOR. A terminate-wait primitive (`in_data[3:0]` = 5) in a frame pulses `frame_end` for one cycle. `crc_good` is high when the last descrambled dword equals the CRC, and low for a frame with no data dwords.
- R9: The terminate-wait that closes a frame gives `reply_code` 4 (good end) when `crc_good` is set, and 5 (bad end) when it is not.
- R10: A terminate-wait outside a frame gives `reply_code` 4 with no `frame_end` pulse.
- R11: A start of frame inside an open frame discards what was gathered, delivers nothing, and restarts the scrambler and the CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming dword present this cycle |
| in_prim | input | 1 | Incoming dword is a primitive |
| in_data | input | 32 | Dword; bits 3:0 carry the primitive code when `in_prim` is set |
| reply_code | output | 3 | Primitive to send back |
| pay_valid | output | 1 | `pay_data` holds a delivered payload dword |
| pay_data | output | 32 | Descrambled payload dword |
| frame_end | output | 1 | One-cycle pulse when a frame closes |
| crc_good | output | 1 | Checksum result, valid with `frame_end` |

## Verification
Frames with zero to seven payload dwords are sent twice each, once with a correct checksum and once with a single bit flipped. Every length then checks the scrambler index, payload order and CRC in both outcomes. The bench puts holds, ends, stray primitives and idle gaps inside frames to show which codes change the reply and which leave it alone. Empty frames, terminate-wait outside any frame, and a start of frame inside a frame test the edges of the frame state.

// File: rtl/lrx_pkg.sv
package lrx_pkg;

  localparam int DW = 32;
  localparam int SW = 16;

  localparam logic [3:0] K_XRDY = 4'd1;
  localparam logic [3:0] K_SOF  = 4'd2;
  localparam logic [3:0] K_HOLD = 4'd3;
  localparam logic [3:0] K_EOF  = 4'd4;
  localparam logic [3:0] K_WTRM = 4'd5;

  typedef enum logic [2:0] {
    RP_SYNC  = 3'd0,
    RP_RRDY  = 3'd1,
    RP_RIP   = 3'd2,
    RP_HOLDA = 3'd3,
    RP_ROK   = 3'd4,
    RP_RERR  = 3'd5
  } reply_e;

  typedef struct packed {
    logic [SW-1:0] st;
    logic [DW-1:0] word;
  } scr_t;

  // One scrambler word: 32 serial bits, earliest bit lands in the MSB.
  function automatic scr_t scr_step(input logic [SW-1:0] s_in);
    scr_t r;
    logic [SW-1:0] s;
    logic fb;
    s = s_in;
    r.word = '0;
    for (int i = 0; i < DW; i++) begin
      r.word = {r.word[DW-2:0], s[15]};
      fb = s[15] ^ s[14] ^ s[12] ^ s[3];
      s = {s[SW-2:0], fb};
    end
    r.st = s;
    return r;
  endfunction

  // CRC-32, MSB first, one dword.
  function automatic logic [DW-1:0] crc_step(input logic [DW-1:0] c_in,
                                             input logic [DW-1:0] d,
                                             input logic [DW-1:0] poly);
    logic [DW-1:0] c;
    logic fb;
    c = c_in;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = c[DW-1] ^ d[i];
      c = {c[DW-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

  // Reply selection from the received dword and frame state.
  function automatic reply_e next_reply(input logic vld, input logic prim,
                                        input logic [3:0] kind,
                                        input logic in_frame,
                                        input logic crc_ok,
                                        input reply_e cur);
    reply_e r;
    if (!vld)                        r = cur;
    else if (prim && kind == K_HOLD) r = RP_HOLDA;
    else if (prim && kind == K_WTRM) r = (in_frame && !crc_ok) ? RP_RERR : RP_ROK;
    else if (prim && kind == K_EOF)  r = cur;
    else if (prim && kind == K_SOF)  r = RP_RIP;
    else if (in_frame)               r = RP_RIP;
    else if (prim && kind == K_XRDY) r = RP_RRDY;
    else                             r = RP_SYNC;
    return r;
  endfunction

endpackage

// File: rtl/lrx_scrambler.sv
module lrx_scrambler
  import lrx_pkg::*;
#(
  parameter logic [SW-1:0] SEED = 16'hF0F6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          advance,
  output logic [DW-1:0] mask
);
  logic [SW-1:0] state_q;
  scr_t          nxt;

  always_comb nxt = scr_step(state_q);
  assign mask = nxt.word;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) state_q <= SEED;
    else if (advance)      state_q <= nxt.st;
  end
endmodule

// File: rtl/lrx_crc.sv
module lrx_crc
  import lrx_pkg::*;
#(
  parameter logic [DW-1:0] POLY = 32'h04C11DB7,
  parameter logic [DW-1:0] SEED = 32'h52325032
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          update,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] crc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || init) crc_q <= SEED;
    else if (update)    crc_q <= crc_step(crc_q, din, POLY);
  end
endmodule

// File: rtl/link_rx_responder.sv
module link_rx_responder
  import lrx_pkg::*;
#(
  parameter logic [DW-1:0] CRC_POLY = 32'h04C11DB7,
  parameter logic [DW-1:0] CRC_SEED = 32'h52325032,
  parameter logic [SW-1:0] SCR_SEED = 16'hF0F6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_prim,
  input  logic [31:0]   in_data,
  output logic [2:0]    reply_code,
  output logic          pay_valid,
  output logic [31:0]   pay_data,
  output logic          frame_end,
  output logic          crc_good
);
  logic          in_frame_q;
  logic          have_pend_q;
  logic [DW-1:0] pend_q;
  reply_e        reply_q;

  logic [DW-1:0] scr_mask;
  logic [DW-1:0] crc_q;
  logic [DW-1:0] desc;

  // Named events for the checker.
  logic ev_prim, ev_sof, ev_wtrm, ev_data, ev_close, ev_deliver, crc_match;

  assign ev_prim    = in_valid && in_prim;
  assign ev_sof     = ev_prim && in_data[3:0] == K_SOF;
  assign ev_wtrm    = ev_prim && in_data[3:0] == K_WTRM;
  assign ev_data    = in_valid && !in_prim && in_frame_q;
  assign ev_close   = ev_wtrm && in_frame_q;
  assign ev_deliver = ev_data && have_pend_q;
  assign crc_match  = have_pend_q && (pend_q == crc_q);
  assign desc       = in_data ^ scr_mask;

  lrx_scrambler #(.SEED(SCR_SEED)) u_scr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ev_sof),
    .advance (ev_data),
    .mask    (scr_mask)
  );

  lrx_crc #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .init   (ev_sof),
    .update (ev_deliver),
    .din    (pend_q),
    .crc_q  (crc_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q  <= 1'b0;
      have_pend_q <= 1'b0;
      pend_q      <= '0;
      reply_q     <= RP_SYNC;
      pay_valid   <= 1'b0;
      pay_data    <= '0;
      frame_end   <= 1'b0;
      crc_good    <= 1'b0;
    end else begin
      reply_q   <= next_reply(in_valid, in_prim, in_data[3:0], in_frame_q,
                              crc_match, reply_q);
      pay_valid <= ev_deliver;
      frame_end <= ev_close;
      if (ev_deliver) pay_data <= pend_q;
      if (ev_close)   crc_good <= crc_match;
      if (ev_sof) begin
        in_frame_q  <= 1'b1;
        have_pend_q <= 1'b0;
      end else if (ev_close) begin
        in_frame_q  <= 1'b0;
        have_pend_q <= 1'b0;
      end else if (ev_data) begin
        pend_q      <= desc;
        have_pend_q <= 1'b1;
      end
    end
  end

  assign reply_code = reply_q;
endmodule

// File: rtl/lrx_checker.sv
module lrx_checker
  import lrx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_prim,
  input logic [31:0] in_data,
  input logic        in_frame,
  input logic        ev_data,
  input logic [2:0]  reply_code,
  input logic        pay_valid,
  input logic        frame_end,
  input logic        crc_good
);
  logic is_hold, is_xrdy, is_eof, is_wtrm;
  assign is_hold = in_valid && in_prim && in_data[3:0] == K_HOLD;
  assign is_xrdy = in_valid && in_prim && in_data[3:0] == K_XRDY;
  assign is_eof  = in_valid && in_prim && in_data[3:0] == K_EOF;
  assign is_wtrm = in_valid && in_prim && in_data[3:0] == K_WTRM;

  p_xrdy_reply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_xrdy && !in_frame |=> reply_code == 3'd1);

  p_hold_reply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_hold |=> reply_code == 3'd3);

  p_eof_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_eof |=> $stable(reply_code));

  p_idle_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(reply_code));

  p_pay_from_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> $past(ev_data));

  p_end_from_wtrm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> $past(is_wtrm && in_frame));

  p_end_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> reply_code == (crc_good ? 3'd4 : 3'd5));

  p_wtrm_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_wtrm && !in_frame |=> reply_code == 3'd4 && !frame_end);

  p_reply_legal: assert property (@(posedge clk) disable iff (!rst_n)
    reply_code <= 3'd5);
endmodule

bind link_rx_responder lrx_checker u_lrx_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_prim    (in_prim),
  .in_data    (in_data),
  .in_frame   (in_frame_q),
  .ev_data    (ev_data),
  .reply_code (reply_code),
  .pay_valid  (pay_valid),
  .frame_end  (frame_end),
  .crc_good   (crc_good)
);

// File: tb/link_rx_responder_bench.sv
module link_rx_responder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_prim = 1'b0;
  logic [31:0] in_data = '0;
  logic [2:0]  reply_code;
  logic        pay_valid;
  logic [31:0] pay_data;
  logic        frame_end;
  logic        crc_good;

  int checks = 0;
  int errors = 0;
  logic [31:0] scr_tab [MAXW];

  always #(CLK_PERIOD / 2) clk = ~clk;

  link_rx_responder u_link_rx_responder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_prim(in_prim),
    .in_data(in_data), .reply_code(reply_code), .pay_valid(pay_valid),
    .pay_data(pay_data), .frame_end(frame_end), .crc_good(crc_good)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Inputs change at negedge; outputs are read at the following negedge.
  task automatic push(input logic p, input logic [31:0] d);
    in_valid = 1'b1; in_prim = p; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] crc_ref(input logic [31:0] c_in, input logic [31:0] d);
    logic [31:0] c;
    c = c_in ^ d;
    repeat (32) c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
    return c;
  endfunction

  // Scrambler words written as a bit stream with integer taps.
  task automatic build_scr();
    int s;
    s = 32'hF0F6;
    for (int k = 0; k < MAXW; k++) begin
      logic [31:0] w;
      w = '0;
      for (int i = 0; i < 32; i++) begin
        int b;
        b = (s >> 15) & 1;
        w = w | (32'(b) << (31 - i));
        s = ((s << 1) | (((s >> 15) ^ (s >> 14) ^ (s >> 12) ^ (s >> 3)) & 1)) & 32'hFFFF;
      end
      scr_tab[k] = w;
    end
  endtask

  // n payload dwords plus a checksum dword; flip one bit when bad is set.
  task automatic frame(input int n, input bit bad, input bit with_hold);
    logic [31:0] pl [MAXW];
    logic [31:0] c;
    c = 32'h52325032;
    for (int k = 0; k < n; k++) begin
      pl[k] = (32'(k + 1) * 32'h9E3779B9) ^ 32'(n << 20);
      c = crc_ref(c, pl[k]);
    end
    pl[n] = bad ? (c ^ 32'h0000_0100) : c;
    push(1'b1, 32'd1);
    chk("R2 xrdy reply", 32'(reply_code), 32'd1);
    push(1'b1, 32'd2);
    chk("R4 sof reply", 32'(reply_code), 32'd2);
    for (int k = 0; k <= n; k++) begin
      push(1'b0, pl[k] ^ scr_tab[k]);
      chk("R4 data reply", 32'(reply_code), 32'd2);
      chk("R7 pay_valid", 32'(pay_valid), (k > 0) ? 32'd1 : 32'd0);
      if (k > 0) chk("R6 R7 descrambled payload", pay_data, pl[k-1]);
      if (with_hold && k == 0) begin
        push(1'b1, 32'd3);
        chk("R3 hold in frame", 32'(reply_code), 32'd3);
        chk("R7 no pay on hold", 32'(pay_valid), 32'd0);
        idle();
        chk("R5 idle keeps reply", 32'(reply_code), 32'd3);
        push(1'b1, 32'd9);
        chk("R4 other prim in frame", 32'(reply_code), 32'd2);
      end
    end
    push(1'b1, 32'd4);
    chk("R5 eof keeps reply", 32'(reply_code), 32'd2);
    chk("R7 no pay on eof", 32'(pay_valid), 32'd0);
    push(1'b1, 32'd5);
    chk("R8 frame_end", 32'(frame_end), 32'd1);
    chk("R8 crc_good", 32'(crc_good), bad ? 32'd0 : 32'd1);
    chk("R9 end reply", 32'(reply_code), bad ? 32'd5 : 32'd4);
    idle();
    chk("R8 frame_end one cycle", 32'(frame_end), 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    build_scr();
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset reply", 32'(reply_code), 32'd0);
    chk("R1 reset pay_valid", 32'(pay_valid), 32'd0);
    chk("R1 reset frame_end", 32'(frame_end), 32'd0);
    rst_n = 1'b1;
    idle();
    chk("R1 reply after release", 32'(reply_code), 32'd0);

    // Outside-frame replies.
    push(1'b1, 32'd3);
    chk("R3 hold outside", 32'(reply_code), 32'd3);
    push(1'b1, 32'd0);
    chk("R5 other prim outside", 32'(reply_code), 32'd0);
    push(1'b1, 32'd1);
    chk("R2 xrdy", 32'(reply_code), 32'd1);
    push(1'b1, 32'd4);
    chk("R5 eof outside keeps", 32'(reply_code), 32'd1);
    push(1'b0, 32'h1234_5678);
    chk("R5 data outside", 32'(reply_code), 32'd0);
    chk("R7 no pay outside", 32'(pay_valid), 32'd0);
    push(1'b1, 32'd5);
    chk("R10 wtrm outside reply", 32'(reply_code), 32'd4);
    chk("R10 no frame_end", 32'(frame_end), 32'd0);

    // Length sweep, good and bad checksum.
    for (int n = 0; n < 8; n++) begin
      frame(n, 1'b0, n == 2);
      frame(n, 1'b1, 1'b0);
    end

    // Empty frame.
    push(1'b1, 32'd2);
    push(1'b1, 32'd5);
    chk("R8 empty frame end", 32'(frame_end), 32'd1);
    chk("R8 empty crc_good", 32'(crc_good), 32'd0);
    chk("R9 empty reply", 32'(reply_code), 32'd5);

    // Restart inside a frame.
    push(1'b1, 32'd2);
    push(1'b0, 32'hDEAD_BEEF);
    push(1'b0, 32'hCAFE_F00D);
    chk("R11 pay before restart", 32'(pay_valid), 32'd1);
    push(1'b1, 32'd2);
    chk("R11 restart reply", 32'(reply_code), 32'd2);
    chk("R11 nothing delivered on restart", 32'(pay_valid), 32'd0);
    begin
      logic [31:0] p0, c;
      p0 = 32'h0BAD_F00D;
      c  = crc_ref(32'h52325032, p0);
      push(1'b0, p0 ^ scr_tab[0]);
      chk("R11 no pay first after restart", 32'(pay_valid), 32'd0);
      push(1'b0, c ^ scr_tab[1]);
      chk("R11 first dword after restart", pay_data, p0);
      push(1'b1, 32'd5);
      chk("R11 crc after restart", 32'(crc_good), 32'd1);
      chk("R11 reply after restart", 32'(reply_code), 32'd4);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule